// File: doc/BRIEF.md
# Parallel Memory Read-Port Power Manager

This block is the read-side control of an asynchronous parallel memory, modelled in a sampled clock domain. It takes active-low chip-select, output-enable and write-enable, plus an address bus. It drives a 16-bit data output with a separate drive-enable, and a pad cell turns the pair into a tri-state pin. The array itself sits outside the block behind a simple read port: an address, an enable and a combinational word.

The block registers the bus pins every clock and finds transitions by comparing each sample with the one before it. A read counts as complete once the address has stayed steady for a configurable number of sampled cycles while the part is selected, the output is enabled and write-enable is idle. After that the block drops into an automatic low-power state. The array port is switched off and the bus keeps showing the last word from a holding register. The next address change, select edge or output-enable edge switches the array port back on in the very cycle that change is sampled, so leaving low-power costs no extra latency. After power-up with the part selected, low-power entry is blocked until the address moves for the first time or select is seen high.

Top module: `mem_rd_pwr_mgr`

## Requirements
- R1: `dq_oe` is high exactly when the latest sampled chip-select and output-enable are both low. While `dq_oe` is low, `dq_out` is all zeros and the pad is high impedance.
- R2: While `dq_oe` is high, `dq_out` equals the array word at the latest sampled address, in the active state and in low-power alike. `mem_addr` carries the latest sampled address.
- R3: `power_state` is encoded 2'b00 standby, 2'b01 active and 2'b10 auto-low-power. Chip-select high at an input sample gives standby on the following clock edge, and reset gives standby.
- R4: Auto-low-power is entered once chip-select low, output-enable low and write-enable high have held for ACC_CYC consecutive sampled cycles with no address, chip-select or output-enable transition. It is entered only from the active state.
- R5: An address change, a chip-select falling edge or an output-enable falling edge seen while in low-power raises `mem_en` in the cycle it is sampled and returns `power_state` to active on the next edge.
- R6: In low-power, `mem_en` stays low unless a transition from R5 is present. Output-enable rising, or write-enable activity, does not leave low-power.
- R7: After reset with chip-select held low, low-power is never entered until the first address transition or until chip-select is sampled high. Output-enable edges alone do not lift this block.
- R8: While write-enable is low, the access count does not advance, so low-power is not entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip-select, active low |
| oe_n | input | 1 | Output-enable, active low |
| we_n | input | 1 | Write-enable, active low |
| addr | input | AW | Word address |
| mem_rdata | input | 16 | Array word for `mem_addr` (combinational) |
| mem_addr | output | AW | Array read address |
| mem_en | output | 1 | Array read port enable |
| dq_out | output | 16 | Data toward the pad |
| dq_oe | output | 1 | Pad drive enable; low means high impedance |
| power_state | output | 2 | 00 standby, 01 active, 10 auto-low-power |

## Verification
The bench steers into the power-up inhibit. It toggles output-enable and holds the address after reset, so a design that lifted the inhibit on any edge would drop to low-power too early. It also runs a second reset with select high, where a design that ignored the select-high path would never save power. It exits low-power by address, select and output-enable edges and checks that the array port wakes in the same cycle: a design that waited for the state register would put stale held data on the bus for one cycle. Short address dwells, write-enable held low and output-enable rising while in low-power are aimed at counters that do not restart, that ignore the write strobe, or that treat any control edge as a wake-up.

// File: rtl/mem_rd_pwr_pkg.sv
package mem_rd_pwr_pkg;

  typedef enum logic [1:0] {
    PS_STBY = 2'b00,
    PS_ACT  = 2'b01,
    PS_LOWP = 2'b10
  } pwr_state_e;

  typedef struct packed {
    logic addr_chg;
    logic cs_fall;
    logic oe_fall;
  } bus_evt_t;

endpackage

// File: rtl/mem_rd_sampler.sv
module mem_rd_sampler
  import mem_rd_pwr_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  output logic          smp_vld,
  output logic          smp_cs_n,
  output logic          smp_oe_n,
  output logic          smp_we_n,
  output logic [AW-1:0] smp_addr,
  output bus_evt_t      evt
);

  logic [1:0]    vld_q;
  logic [1:0]    vld_d;
  logic          prv_cs_n;
  logic          prv_oe_n;
  logic [AW-1:0] prv_addr;
  logic          hist_vld;

  always_comb begin
    vld_d = {vld_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= '0;
      smp_cs_n <= 1'b1;
      smp_oe_n <= 1'b1;
      smp_we_n <= 1'b1;
      smp_addr <= '0;
      prv_cs_n <= 1'b1;
      prv_oe_n <= 1'b1;
      prv_addr <= '0;
    end else begin
      vld_q    <= vld_d;
      smp_cs_n <= cs_n;
      smp_oe_n <= oe_n;
      smp_we_n <= we_n;
      smp_addr <= addr;
      prv_cs_n <= smp_cs_n;
      prv_oe_n <= smp_oe_n;
      prv_addr <= smp_addr;
    end
  end

  assign smp_vld  = vld_q[0];
  assign hist_vld = vld_q[1];

  always_comb begin
    evt.addr_chg = hist_vld & (smp_addr != prv_addr);
    evt.cs_fall  = hist_vld & prv_cs_n & ~smp_cs_n;
    evt.oe_fall  = hist_vld & prv_oe_n & ~smp_oe_n;
  end

endmodule

// File: rtl/mem_rd_acc_timer.sv
module mem_rd_acc_timer #(
  parameter int ACC_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_cond,
  input  logic restart,
  output logic rd_done_d
);

  localparam int CW = $clog2(ACC_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(ACC_CYC);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (!rd_cond) begin
      cnt_d = '0;
    end else if (restart) begin
      cnt_d = ONE;
    end else if (cnt_q == LIM) begin
      cnt_d = LIM;
    end else begin
      cnt_d = cnt_q + ONE;
    end
    rd_done_d = (cnt_d == LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/mem_rd_pwr_fsm.sv
module mem_rd_pwr_fsm
  import mem_rd_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_vld,
  input  logic       smp_cs_n,
  input  logic       restart,
  input  logic       addr_chg,
  input  logic       rd_done_d,
  output pwr_state_e state_q
);

  pwr_state_e state_d;
  logic       inh_q;
  logic       inh_d;
  logic       sel;

  always_comb begin
    sel   = smp_vld & ~smp_cs_n;
    inh_d = inh_q & ~(addr_chg | (smp_vld & smp_cs_n));
    if (!sel) begin
      state_d = PS_STBY;
    end else if (restart) begin
      state_d = PS_ACT;
    end else if (state_q == PS_LOWP) begin
      state_d = PS_LOWP;
    end else if (rd_done_d && !inh_d) begin
      state_d = PS_LOWP;
    end else begin
      state_d = PS_ACT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_STBY;
      inh_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      inh_q   <= inh_d;
    end
  end

endmodule

// File: rtl/mem_rd_dq_gate.sv
module mem_rd_dq_gate
  import mem_rd_pwr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic          smp_cs_n,
  input  logic          smp_oe_n,
  input  pwr_state_e    state_q,
  input  logic          restart,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_en,
  output logic          dq_oe,
  output logic [DW-1:0] dq_out
);

  logic [DW-1:0] hold_q;
  logic [DW-1:0] hold_d;
  logic          sel;

  always_comb begin
    sel    = smp_vld & ~smp_cs_n;
    mem_en = sel & ((state_q != PS_LOWP) | restart);
    dq_oe  = sel & ~smp_oe_n;
    hold_d = mem_en ? mem_rdata : hold_q;
    if (!dq_oe) begin
      dq_out = '0;
    end else if (mem_en) begin
      dq_out = mem_rdata;
    end else begin
      dq_out = hold_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_d;
    end
  end

endmodule

// File: rtl/mem_rd_pwr_mgr.sv
module mem_rd_pwr_mgr
  import mem_rd_pwr_pkg::*;
#(
  parameter int AW         = 12,
  parameter int ACC_CYC    = 4,
  parameter int RST_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_en,
  output logic [15:0]   dq_out,
  output logic          dq_oe,
  output logic [1:0]    power_state
);

  localparam int DW = 16;

  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_int_n;
  logic                  smp_vld;
  logic                  smp_cs_n;
  logic                  smp_oe_n;
  logic                  smp_we_n;
  logic [AW-1:0]         smp_addr;
  bus_evt_t              evt;
  logic                  restart;
  logic                  rd_cond;
  logic                  rd_done_d;
  pwr_state_e            state_q;

  generate
    if (RST_STAGES == 1) begin : g_rst1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= 1'b1;
      end
    end else begin : g_rstn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_int_n = rst_sync_q[RST_STAGES-1];

  mem_rd_sampler #(.AW(AW)) u_smp (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cs_n     (cs_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .addr     (addr),
    .smp_vld  (smp_vld),
    .smp_cs_n (smp_cs_n),
    .smp_oe_n (smp_oe_n),
    .smp_we_n (smp_we_n),
    .smp_addr (smp_addr),
    .evt      (evt)
  );

  always_comb begin
    restart = evt.addr_chg | evt.cs_fall | evt.oe_fall;
    rd_cond = smp_vld & ~smp_cs_n & ~smp_oe_n & smp_we_n;
  end

  mem_rd_acc_timer #(.ACC_CYC(ACC_CYC)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rd_cond   (rd_cond),
    .restart   (restart),
    .rd_done_d (rd_done_d)
  );

  mem_rd_pwr_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .smp_vld   (smp_vld),
    .smp_cs_n  (smp_cs_n),
    .restart   (restart),
    .addr_chg  (evt.addr_chg),
    .rd_done_d (rd_done_d),
    .state_q   (state_q)
  );

  mem_rd_dq_gate #(.DW(DW)) u_dq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .smp_vld   (smp_vld),
    .smp_cs_n  (smp_cs_n),
    .smp_oe_n  (smp_oe_n),
    .state_q   (state_q),
    .restart   (restart),
    .mem_rdata (mem_rdata),
    .mem_en    (mem_en),
    .dq_oe     (dq_oe),
    .dq_out    (dq_out)
  );

  assign mem_addr    = smp_addr;
  assign power_state = state_q;

endmodule

// File: rtl/mem_rd_pwr_mgr_chk.sv
module mem_rd_pwr_mgr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       oe_n,
  input logic       dq_oe,
  input logic       mem_en,
  input logic [1:0] power_state
);

  // R3: only the three defined encodings appear
  assert_state_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(power_state));

  // R1: bus is driven only if select and output-enable were both low at the sample
  assert_drive_needs_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> ($past(cs_n) == 1'b0 && $past(oe_n) == 1'b0));

  // R3: select high at a sample gives standby after the next edge
  assert_deselect_standby_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n, 2) |-> power_state == 2'b00);

  // R4: low-power is reached only from the active state
  assert_lowp_from_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_state == 2'b10) |-> $past(power_state) == 2'b01);

  // R5: an array wake-up during low-power leaves low-power at the next edge
  assert_wake_leaves_lowp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (power_state == 2'b10 && mem_en) |=> power_state != 2'b10);

endmodule

bind mem_rd_pwr_mgr mem_rd_pwr_mgr_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .oe_n        (oe_n),
  .dq_oe       (dq_oe),
  .mem_en      (mem_en),
  .power_state (power_state)
);

// File: tb/mem_rd_pwr_mgr_tb_top.sv
module mem_rd_pwr_mgr_tb_top;

  localparam int AW  = 12;
  localparam int ACC = 4;

  logic          clk;
  logic          rst_n;
  logic          cs_n;
  logic          oe_n;
  logic          we_n;
  logic [AW-1:0] addr;
  logic [15:0]   mem_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_en;
  logic [15:0]   dq_out;
  logic          dq_oe;
  logic [1:0]    power_state;

  int n_chk;
  int n_bad;
  bit done;

  mem_rd_pwr_mgr #(.AW(AW), .ACC_CYC(ACC)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .oe_n        (oe_n),
    .we_n        (we_n),
    .addr        (addr),
    .mem_rdata   (mem_rdata),
    .mem_addr    (mem_addr),
    .mem_en      (mem_en),
    .dq_out      (dq_out),
    .dq_oe       (dq_oe),
    .power_state (power_state)
  );

  function automatic logic [15:0] arr_word(logic [AW-1:0] a);
    return (16'(a) * 16'd37) ^ 16'h5A3C;
  endfunction

  assign mem_rdata = arr_word(mem_addr);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- behavioural reference ----------------
  int            m_rs;
  int            m_vld;
  int            m_cnt;
  bit            m_inh;
  logic [1:0]    m_st;
  logic          s_cs, s_oe, s_we, p_cs, p_oe;
  logic [AW-1:0] s_a, p_a;

  function automatic bit m_wake();
    if (m_vld < 2) return 1'b0;
    return (s_a != p_a) || (p_cs && !s_cs) || (p_oe && !s_oe);
  endfunction

  task automatic m_clear();
    m_vld = 0; m_cnt = 0; m_inh = 1'b1; m_st = 2'b00;
    s_cs = 1'b1; s_oe = 1'b1; s_we = 1'b1; s_a = '0;
    p_cs = 1'b1; p_oe = 1'b1; p_a = '0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs = 0;
      m_clear();
    end else if (m_rs < 2) begin
      m_rs++;
      m_clear();
    end else begin
      bit wk, achg, sel, cond;
      wk   = m_wake();
      achg = (m_vld >= 2) && (s_a != p_a);
      sel  = (m_vld >= 1) && !s_cs;
      cond = sel && !s_oe && s_we;
      if (!cond)              m_cnt = 0;
      else if (wk)            m_cnt = 1;
      else if (m_cnt < ACC)   m_cnt = m_cnt + 1;
      if (achg || ((m_vld >= 1) && s_cs)) m_inh = 1'b0;
      if (!sel)                           m_st = 2'b00;
      else if (wk)                        m_st = 2'b01;
      else if (m_st == 2'b10)             m_st = 2'b10;
      else if (m_cnt == ACC && !m_inh)    m_st = 2'b10;
      else                                m_st = 2'b01;
      p_cs = s_cs; p_oe = s_oe; p_a = s_a;
      s_cs = cs_n; s_oe = oe_n; s_we = we_n; s_a = addr;
      if (m_vld < 2) m_vld++;
    end
  end

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!done) begin
      logic          e_oe, e_en;
      logic [15:0]   e_dq;
      e_oe = (m_vld >= 1) && !s_cs && !s_oe;
      e_en = (m_vld >= 1) && !s_cs && ((m_st != 2'b10) || m_wake());
      e_dq = e_oe ? arr_word(s_a) : 16'h0;
      cmp("R1 dq_oe", 32'(dq_oe), 32'(e_oe));
      cmp("R2 dq_out", 32'(dq_out), 32'(e_dq));
      cmp("R2 mem_addr", 32'(mem_addr), 32'(s_a));
      cmp("R5 R6 mem_en", 32'(mem_en), 32'(e_en));
      cmp("R3 R4 R7 R8 power_state", 32'(power_state), 32'(m_st));
    end
  end

  // ---------------- scenario checks ----------------
  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_ps(string tag, logic [1:0] exp);
    cmp(tag, 32'(power_state), 32'(exp));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = 12'h005;
    cyc(4);
    expect_ps("R3 reset standby", 2'b00);
    cmp("R1 reset no drive", 32'(dq_oe), 32'd0);
    rst_n = 1'b1;
    cyc(20);
    expect_ps("R7 inhibited after power-up", 2'b01);
    cmp("R2 data at addr 5", 32'(dq_out), 32'(arr_word(12'h005)));

    // first address change lifts inhibit, then a full access
    addr = 12'h006;
    cyc(4);
    expect_ps("R4 not yet low-power", 2'b01);
    cyc(1);
    expect_ps("R4 low-power entered", 2'b10);
    cmp("R6 array off in low-power", 32'(mem_en), 32'd0);
    cmp("R2 held data in low-power", 32'(dq_out), 32'(arr_word(12'h006)));

    // output-enable rising does not wake
    oe_n = 1'b1;
    cyc(3);
    expect_ps("R6 oe rise keeps low-power", 2'b10);
    cmp("R1 bus released", 32'(dq_oe), 32'd0);
    oe_n = 1'b0;
    cyc(1);
    cmp("R5 oe fall wakes array at once", 32'(mem_en), 32'd1);
    cyc(1);
    expect_ps("R5 active after oe fall", 2'b01);
    cyc(3);
    expect_ps("R4 low-power again", 2'b10);

    // address change in low-power: no access penalty
    addr = 12'h007;
    cyc(1);
    cmp("R5 array awake on addr change", 32'(mem_en), 32'd1);
    cmp("R5 new word at once", 32'(dq_out), 32'(arr_word(12'h007)));
    cyc(1);
    expect_ps("R5 active after addr change", 2'b01);

    // write-enable low blocks counting
    addr = 12'h008; we_n = 1'b0;
    cyc(10);
    expect_ps("R8 no low-power with we low", 2'b01);
    we_n = 1'b1;
    cyc(5);
    expect_ps("R8 low-power after we idle", 2'b10);
    we_n = 1'b0;
    cyc(3);
    expect_ps("R6 we activity keeps low-power", 2'b10);
    we_n = 1'b1;

    // deselect and reselect
    cs_n = 1'b1;
    cyc(2);
    expect_ps("R3 standby on deselect", 2'b00);
    cs_n = 1'b0;
    cyc(1);
    cmp("R5 cs fall enables array", 32'(mem_en), 32'd1);
    cyc(1);
    expect_ps("R5 active after cs fall", 2'b01);
    cyc(3);
    expect_ps("R4 low-power after reselect", 2'b10);

    // short address dwell never completes an access
    for (int i = 0; i < 6; i++) begin
      addr = 12'(12'h100 + i);
      cyc(2);
    end
    expect_ps("R4 short dwell stays active", 2'b01);
    cyc(4);
    expect_ps("R4 low-power after steady address", 2'b10);

    // power-up with select high: inhibit lifted by select high
    rst_n = 1'b0; cs_n = 1'b1; addr = 12'h020;
    cyc(3);
    rst_n = 1'b1;
    cyc(10);
    expect_ps("R3 standby while deselected", 2'b00);
    cs_n = 1'b0;
    cyc(5);
    expect_ps("R7 inhibit cleared by select high", 2'b10);

    // power-up selected, output-enable edges only: inhibit holds
    rst_n = 1'b0; cs_n = 1'b0; oe_n = 1'b0; addr = 12'h030;
    cyc(3);
    rst_n = 1'b1;
    cyc(8);
    oe_n = 1'b1;
    cyc(3);
    oe_n = 1'b0;
    cyc(12);
    expect_ps("R7 oe edges keep inhibit", 2'b01);
    addr = 12'h031;
    cyc(5);
    expect_ps("R7 address change frees low-power", 2'b10);

    cyc(2);
    finish_run();
  end

endmodule